// File: doc/BRIEF.md
# Shared-Buffer Output Link Scheduler

This block arbitrates one output link of a central crossbar stage whose link owns only a few one-cell buffers. Those buffers are shared by every input link, so there is no dedicated queue per input. In every slot the block reads a vector of mapped requests, one bit per input link. It grants as many of them as it has free buffers, walking the inputs in round-robin order. It keeps the number of free buffers in a credit counter.

Each grant is presented for one slot. During that slot the input side answers with an accept vector. An accepted grant lands its cell in the lowest-numbered free buffer. A grant that is not accepted gives its credit back at once.

Buffered cells are offered toward the output module one at a time, in the order they arrived. A one-hot buffer select and the index of the input that sent the cell go with each offered cell. An exit strobe removes the offered cell and returns its credit. Cell storage is represented only by occupancy flags and source tags.

Top module: `cbs_out_sched`

## Requirements
- R1: After a synchronous reset, `grant_o` is all zero, `deq_valid_o` is low and all NBUF credits are free, so a full request vector is granted NBUF inputs on the next slot.
- R2: A grant bit is set only for an input whose request bit was high in the slot before the grant appears.
- R3: The number of grant bits set in one slot never exceeds the free credits. With zero credits no grant is issued whatever the requests.
- R4: Grants go to requesting inputs in round-robin order. The search starts one past the last input granted, wrapping from N_IN-1 to 0, and the first inputs in that order receive the grants up to the credit limit.
- R5: A request sampled at a clock edge shows up as a grant right after that edge. The grant is held for exactly one slot.
- R6: A grant whose `acc_i` bit is low during its grant slot is declined, and its credit can be granted again on the next edge.
- R7: An accepted cell sets `deq_valid_o` right after the accepting edge. `deq_sel_o` is then one-hot and points at an occupied buffer.
- R8: Cells leave first-come-first-served. Cells accepted at the same edge leave in ascending input index. `deq_src_o` gives the input index of the offered cell.
- R9: `take_i` while `deq_valid_o` is high removes exactly one cell and returns one credit. `take_i` while `deq_valid_o` is low has no effect.
- R10: Any buffer may hold a cell from any input, so a single input can occupy all NBUF buffers at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_IN | Mapped requests, one bit per input link |
| acc_i | input | N_IN | Accept answer for the grants presented this slot |
| take_i | input | 1 | Exit strobe: the output module takes the offered cell |
| grant_o | output | N_IN | Registered grant vector |
| deq_valid_o | output | 1 | A buffered cell is offered |
| deq_sel_o | output | NBUF | One-hot select of the offered buffer |
| deq_src_o | output | $clog2(N_IN) | Input index of the offered cell |

## Verification
The bench sweeps a 4-input, 2-buffer configuration through all sixteen request patterns. It mixes in pseudo-random accept and exit patterns, and a reference model derived from the requirements is compared against every slot. Full request vectors separate correct pointer rotation and credit limiting from a fixed-priority picker. Sparse vectors show that non-requesting inputs are skipped.

Runs with no exits drive the credit count to zero, which shows the grant ceiling. Declined grants and accept-after-exit sequences tell an immediate credit return apart from a lost or duplicated one. Same-edge accepts and one-input bursts check FCFS ordering and buffer sharing.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  function automatic int ones64(input logic [63:0] v);
    int n;
    n = 0;
    for (int i = 0; i < 64; i++) n += int'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/cbs_rr_pick.sv
module cbs_rr_pick #(
  parameter int N  = 8,
  parameter int IW = 3,
  parameter int CW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  input  logic [CW-1:0] budget,
  output logic [N-1:0]  gnt,
  output logic          any,
  output logic [IW-1:0] nxt_ptr
);
  int taken;
  int last;
  int idx;

  always_comb begin
    gnt   = '0;
    taken = 0;
    last  = int'(ptr);
    idx   = 0;
    for (int o = 0; o < N; o++) begin
      idx = int'(ptr) + o;
      if (idx >= N) idx -= N;
      if (req[idx] && (taken < int'(budget))) begin
        gnt[idx] = 1'b1;
        taken++;
        last = idx;
      end
    end
    any     = (taken != 0);
    nxt_ptr = (last == N - 1) ? '0 : IW'(last + 1);
  end
endmodule

// File: rtl/cbs_credit.sv
module cbs_credit
  import cbs_pkg::*;
#(
  parameter int N    = 8,
  parameter int NBUF = 3,
  parameter int CW   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  gnt_new,
  input  logic [N-1:0]  gnt_q,
  input  logic [N-1:0]  acc,
  input  logic          exit_i,
  output logic [CW-1:0] cnt
);
  int cnt_n;

  always_comb begin
    cnt_n = int'(cnt) - ones64(64'(gnt_new)) + ones64(64'(gnt_q & ~acc)) + int'(exit_i);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= CW'(NBUF);
    else     cnt <= CW'(cnt_n);
  end

  p_credit_cap_r3: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= NBUF);

  p_no_grant_empty_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |-> (gnt_new == '0));
endmodule

// File: rtl/cbs_pool.sv
module cbs_pool #(
  parameter int N    = 8,
  parameter int NBUF = 3,
  parameter int IW   = 3,
  parameter int BW   = 2,
  parameter int CW   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    acc_mask,
  input  logic            take_i,
  output logic            deq_valid,
  output logic [NBUF-1:0] deq_sel,
  output logic [IW-1:0]   deq_src,
  output logic [NBUF-1:0] occ
);
  logic [IW-1:0]   tag_q [NBUF];
  logic [IW-1:0]   tag_n [NBUF];
  logic [BW-1:0]   ord_q [NBUF];
  logic [BW-1:0]   ord_n [NBUF];
  logic [NBUF-1:0] occ_n;
  logic [NBUF-1:0] used;
  logic [CW-1:0]   cnt_q;
  logic            found;
  int              cnt_n;

  always_comb begin
    occ_n = occ;
    tag_n = tag_q;
    ord_n = ord_q;
    used  = '0;
    found = 1'b0;
    cnt_n = int'(cnt_q);
    if (take_i && (cnt_q != '0)) begin
      occ_n[ord_q[0]] = 1'b0;
      for (int i = 0; i < NBUF - 1; i++) ord_n[i] = ord_q[i+1];
      cnt_n--;
    end
    for (int i = 0; i < N; i++) begin
      if (acc_mask[i]) begin
        found = 1'b0;
        for (int b = 0; b < NBUF; b++) begin
          if (!found && !occ[b] && !used[b]) begin
            found    = 1'b1;
            used[b]  = 1'b1;
            occ_n[b] = 1'b1;
            tag_n[b] = IW'(i);
            if (cnt_n < NBUF) ord_n[cnt_n] = BW'(b);
            cnt_n++;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ   <= '0;
      cnt_q <= '0;
      for (int b = 0; b < NBUF; b++) begin
        tag_q[b] <= '0;
        ord_q[b] <= '0;
      end
    end else begin
      occ   <= occ_n;
      cnt_q <= CW'(cnt_n);
      tag_q <= tag_n;
      ord_q <= ord_n;
    end
  end

  assign deq_valid = (cnt_q != '0);
  assign deq_src   = tag_q[ord_q[0]];

  always_comb begin
    deq_sel = '0;
    if (deq_valid) deq_sel[ord_q[0]] = 1'b1;
  end

  p_sel_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(deq_sel) && (deq_valid == (deq_sel != '0)));

  p_head_held_r7: assert property (@(posedge clk) disable iff (rst)
    deq_valid |-> ((deq_sel & occ) != '0));

  p_exit_frees_r9: assert property (@(posedge clk) disable iff (rst)
    (deq_valid && take_i) |=> ((occ & $past(deq_sel)) == '0));

  p_fill_count_r10: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) == $countones(occ));
endmodule

// File: rtl/cbs_out_sched.sv
module cbs_out_sched
  import cbs_pkg::*;
#(
  parameter int N_IN = 8,
  parameter int NBUF = 3,
  localparam int IW  = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int BW  = (NBUF > 1) ? $clog2(NBUF) : 1,
  localparam int CW  = $clog2(NBUF + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] req_i,
  input  logic [N_IN-1:0] acc_i,
  input  logic            take_i,
  output logic [N_IN-1:0] grant_o,
  output logic            deq_valid_o,
  output logic [NBUF-1:0] deq_sel_o,
  output logic [IW-1:0]   deq_src_o
);
  logic [N_IN-1:0] gnt_new;
  logic            gnt_any;
  logic [IW-1:0]   rr_ptr;
  logic [IW-1:0]   rr_nxt;
  logic [CW-1:0]   credits;
  logic [NBUF-1:0] occ;

  cbs_rr_pick #(.N(N_IN), .IW(IW), .CW(CW)) u_pick (
    .req     (req_i),
    .ptr     (rr_ptr),
    .budget  (credits),
    .gnt     (gnt_new),
    .any     (gnt_any),
    .nxt_ptr (rr_nxt)
  );

  cbs_credit #(.N(N_IN), .NBUF(NBUF), .CW(CW)) u_credit (
    .clk     (clk),
    .rst     (rst),
    .gnt_new (gnt_new),
    .gnt_q   (grant_o),
    .acc     (acc_i),
    .exit_i  (deq_valid_o & take_i),
    .cnt     (credits)
  );

  cbs_pool #(.N(N_IN), .NBUF(NBUF), .IW(IW), .BW(BW), .CW(CW)) u_pool (
    .clk       (clk),
    .rst       (rst),
    .acc_mask  (grant_o & acc_i),
    .take_i    (take_i),
    .deq_valid (deq_valid_o),
    .deq_sel   (deq_sel_o),
    .deq_src   (deq_src_o),
    .occ       (occ)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_o <= '0;
      rr_ptr  <= '0;
    end else begin
      grant_o <= gnt_new;
      if (gnt_any) rr_ptr <= rr_nxt;
    end
  end

  p_grant_requested_r2: assert property (@(posedge clk) disable iff (rst)
    (grant_o & ~$past(req_i)) == '0);

  p_conserve_r6: assert property (@(posedge clk) disable iff (rst)
    (int'(credits) + $countones(grant_o) + $countones(occ)) == NBUF);

  p_grant_limit_r3: assert property (@(posedge clk) disable iff (rst)
    $countones(gnt_new) <= int'(credits));
endmodule

// File: tb/tb_cbs_out_sched.sv
module tb_cbs_out_sched;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int NB = 2;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req = '0;
  logic [N-1:0]  acc = '0;
  logic          take = 1'b0;
  logic [N-1:0]  grant;
  logic          dvalid;
  logic [NB-1:0] dsel;
  logic [IW-1:0] dsrc;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  int           m_cnt;
  int           m_ptr;
  logic [N-1:0] m_gnt;
  int           m_fifo [8];
  int           m_len;
  logic [15:0]  lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbs_out_sched #(.N_IN(N), .NBUF(NB)) dut (
    .clk(clk), .rst(rst), .req_i(req), .acc_i(acc), .take_i(take),
    .grant_o(grant), .deq_valid_o(dvalid), .deq_sel_o(dsel), .deq_src_o(dsrc)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model(input logic [N-1:0] r, input logic [N-1:0] a, input logic t);
    logic [N-1:0] ng;
    int taken;
    int last;
    int nd;
    int ex;
    ng = '0; taken = 0; last = m_ptr; nd = 0; ex = 0;
    for (int o = 0; o < N; o++) begin
      int idx;
      idx = (m_ptr + o) % N;
      if (r[idx] && taken < m_cnt) begin
        ng[idx] = 1'b1; taken++; last = idx;
      end
    end
    for (int i = 0; i < N; i++) if (m_gnt[i] && !a[i]) nd++;
    if (m_len > 0 && t) begin
      ex = 1;
      for (int i = 0; i < 7; i++) m_fifo[i] = m_fifo[i+1];
      m_len--;
    end
    for (int i = 0; i < N; i++)
      if (m_gnt[i] && a[i]) begin m_fifo[m_len] = i; m_len++; end
    m_cnt = m_cnt - taken + nd + ex;
    if (taken > 0) m_ptr = (last + 1) % N;
    m_gnt = ng;
  endtask

  task automatic step(input logic [N-1:0] r, input logic [N-1:0] a, input logic t);
    @(negedge clk);
    req = r; acc = a; take = t;
    @(posedge clk);
    model(r, a, t);
    #1;
    chk("R4 grant vs model", int'(grant), int'(m_gnt));
    chk("R7 valid vs model", int'(dvalid), int'(m_len > 0));
    if (m_len > 0) begin
      chk("R8 source vs model", int'(dsrc), m_fifo[0]);
      chk("R7 select one-hot", $countones(dsel), 1);
    end
  endtask

  initial begin
    m_cnt = NB; m_ptr = 0; m_gnt = '0; m_len = 0;
    for (int i = 0; i < 8; i++) m_fifo[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 grant at reset", int'(grant), 0);
    chk("R1 valid at reset", int'(dvalid), 0);
    // R1 R3 R5: full requests get NBUF grants in order 0,1
    step(4'b1111, 4'b0000, 1'b0);
    chk("R1 R3 R5 first grants", int'(grant), 4'b0011);
    // R3: no credit left; R8 same-edge accepts
    step(4'b1111, 4'b0011, 1'b0);
    chk("R3 zero credit", int'(grant), 0);
    chk("R8 head is input 0", int'(dsrc), 0);
    step(4'b0000, 4'b0000, 1'b1);
    chk("R8 R9 next is input 1", int'(dsrc), 1);
    chk("R5 grant lasts one slot", int'(grant), 0);
    step(4'b1111, 4'b0000, 1'b1);
    chk("R4 R9 grant after exit", int'(grant), 4'b0100);
    chk("R9 fifo drained", int'(dvalid), 0);
    step(4'b1111, 4'b0000, 1'b0);
    chk("R6 declined credit reused", int'(grant), 4'b1000);
    step(4'b1111, 4'b1000, 1'b0);
    chk("R4 pointer wraps", int'(grant), 4'b0001);
    chk("R7 accepted cell offered", int'(dsrc), 3);
    step(4'b0000, 4'b0001, 1'b0);
    step(4'b1111, 4'b0000, 1'b0);
    chk("R3 buffers full no grant", int'(grant), 0);
    chk("R8 order kept", int'(dsrc), 3);
    step(4'b0000, 4'b0000, 1'b1);
    chk("R8 second cell", int'(dsrc), 0);
    step(4'b0000, 4'b0000, 1'b1);
    step(4'b0000, 4'b0000, 1'b1);
    chk("R9 take on empty ignored", int'(dvalid), 0);
    // R10: one input holds every buffer
    step(4'b0010, 4'b0000, 1'b0);
    chk("R2 only requester granted", int'(grant), 4'b0010);
    step(4'b0010, 4'b0010, 1'b0);
    chk("R10 second grant same input", int'(grant), 4'b0010);
    step(4'b0000, 4'b0010, 1'b0);
    step(4'b0000, 4'b0000, 1'b1);
    chk("R10 both buffers from input 1", int'(dsrc), 1);
    chk("R10 still valid", int'(dvalid), 1);
    step(4'b0000, 4'b0000, 1'b1);
    // sweep of every request pattern with pseudo-random answers (R2 R3 R4 R6 R8 R9)
    for (int p = 0; p < 16; p++) begin
      for (int k = 0; k < 8; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(N'(p), lfsr[3:0], lfsr[5] & (k != 7 || p[0]));
      end
    end
    // credit exhaustion then drain
    for (int k = 0; k < 6; k++) step(4'b1111, 4'b1111, 1'b0);
    for (int k = 0; k < 4; k++) step(4'b0101, 4'b0000, 1'b1);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule